// File: doc/BRIEF.md
# Rotate-Right Unit, 32/64-bit

This block rotates a data word to the right. It supports five operating modes. Two of them work on the low half of the operand. They rotate it as a 32-bit word and then sign-extend the result to 64 bits. The other three rotate the full 64-bit operand.

The rotate amount comes from one of two places:
- A 5-bit immediate. One 64-bit mode adds 32 to the immediate, so immediates alone can reach every amount from 0 to 63.
- The low bits of a separate shift-source operand. The 32-bit register mode takes 5 bits of it and the 64-bit register mode takes 6.

The unit is purely combinational. An execution stage drives the mode, the operands and the immediate, and reads the result back in the same cycle. Instruction decode and register access belong to the surrounding pipeline.

Top module: `rotr_unit`

## Requirements
- R1: Mode code 0 rotates data bits [31:0] right by the 5-bit immediate. The 32-bit result is placed in result bits [31:0] and sign-extended from bit 31 into bits [63:32].
- R2: Mode code 1 rotates data bits [31:0] right by shift-source bits [4:0] and sign-extends like R1. Shift-source bits [63:5] have no effect on the result.
- R3: Mode code 2 rotates the full 64-bit data operand right by the immediate, an amount from 0 to 31.
- R4: Mode code 3 rotates the full 64-bit data operand right by the immediate plus 32, an amount from 32 to 63.
- R5: Mode code 4 rotates the full 64-bit data operand right by shift-source bits [5:0]. Shift-source bits [63:6] have no effect on the result.
- R6: In modes 0 and 1, data bits [63:32] have no effect on the result.
- R7: A rotate amount of zero returns the operand unchanged. In modes 0 and 1 this is data bits [31:0], sign-extended.
- R8: Mode codes 5, 6 and 7 produce an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 3 | Mode code (0 to 4 valid; 5 to 7 give zero) |
| data_i | input | 64 | Operand to be rotated |
| shsrc_i | input | 64 | Shift-source operand; its low bits give the amount in register modes |
| imm_i | input | 5 | Immediate rotate amount |
| result_o | output | 64 | Rotated (and, for 32-bit modes, sign-extended) result |

## Verification
Random data, shift-source and immediate values are applied in every mode code, including the unused ones. The shift-source operand always carries random upper bits, which shows whether the register modes mask their amount to the right width. Directed cases cover:
- Zero amounts, which separate a pass-through from a mis-wired first stage.
- Amounts 31, 32 and 63, which expose a missing or misplaced plus-32 bias.
- A sign bit set after a 32-bit rotate, which exercises the sign extension.
- Pairs of operands that differ only in their upper half, which show whether the 32-bit modes read bits they must ignore.

// File: rtl/rotr_pkg.sv
package rotr_pkg;
   typedef enum logic [2:0] {
      ROT_W32_IMM = 3'd0,
      ROT_W32_REG = 3'd1,
      ROT_W64_IMM = 3'd2,
      ROT_W64_UP  = 3'd3,
      ROT_W64_REG = 3'd4
   } rot_mode_e;
endpackage

// File: rtl/rotr_amount_sel.sv
module rotr_amount_sel
   import rotr_pkg::*;
#(
   parameter int AMT_W = 6,
   localparam int IMM_W = AMT_W - 1
) (
   input  logic [2:0]       mode,
   input  logic [IMM_W-1:0] imm,
   input  logic [AMT_W-1:0] src,
   output logic [AMT_W-1:0] amt,
   output logic             narrow,
   output logic             valid
);
   always_comb begin
      amt    = '0;
      narrow = 1'b0;
      valid  = 1'b1;
      case (rot_mode_e'(mode))
         ROT_W32_IMM: begin amt = {1'b0, imm};            narrow = 1'b1; end
         ROT_W32_REG: begin amt = {1'b0, src[IMM_W-1:0]}; narrow = 1'b1; end
         ROT_W64_IMM: amt = {1'b0, imm};
         ROT_W64_UP:  amt = {1'b1, imm};
         ROT_W64_REG: amt = src;
         default:     valid = 1'b0;
      endcase
   end

   always_comb begin
      if (rot_mode_e'(mode) == ROT_W64_UP)
         a_r4_upper_range: assert (amt >= AMT_W'(1 << IMM_W));
      if (narrow)
         a_r1_narrow_below_half: assert (amt[AMT_W-1] == 1'b0);
   end
endmodule

// File: rtl/rotr_barrel.sv
module rotr_barrel #(
   parameter int W  = 64,
   localparam int SW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  dout
);
   if (W < 4 || (1 << SW) != W) begin : g_bad_width
      $error("rotr_barrel: W must be a power of two, at least 4");
   end

   logic [W-1:0] stg [SW+1];
   assign stg[0] = din;

   for (genvar k = 0; k < SW; k++) begin : g_stage
      localparam int D = 1 << k;
      assign stg[k+1] = amt[k] ? {stg[k][D-1:0], stg[k][W-1:D]} : stg[k];
   end

   assign dout = stg[SW];

   always_comb begin
      a_r3_ones_kept: assert ($countones(dout) == $countones(din));
   end
endmodule

// File: rtl/rotr_extend.sv
module rotr_extend #(
   parameter int W        = 64,
   parameter bit SIGN_EXT = 1'b1,
   localparam int H       = W / 2
) (
   input  logic [W-1:0] rot,
   input  logic         narrow,
   input  logic         valid,
   output logic [W-1:0] dout
);
   logic [H-1:0] fill;

   if (SIGN_EXT) begin : g_sign
      assign fill = {H{rot[H-1]}};
   end else begin : g_zero
      assign fill = '0;
   end

   always_comb begin
      if (!valid)      dout = '0;
      else if (narrow) dout = {fill, rot[H-1:0]};
      else             dout = rot;
   end
endmodule

// File: rtl/rotr_unit.sv
module rotr_unit
   import rotr_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter bit SIGN_EXT = 1'b1,
   localparam int AMT_W   = $clog2(DATA_W),
   localparam int IMM_W   = AMT_W - 1,
   localparam int HALF_W  = DATA_W / 2
) (
   input  logic [2:0]        mode_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] shsrc_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [DATA_W-1:0] result_o
);
   if ((1 << AMT_W) != DATA_W || DATA_W < 8) begin : g_bad_param
      $error("rotr_unit: DATA_W must be a power of two, at least 8");
   end

   logic [AMT_W-1:0]  amt;
   logic              narrow;
   logic              valid;
   logic [DATA_W-1:0] barrel_in;
   logic [DATA_W-1:0] barrel_out;
   logic              unused_src_hi;

   assign unused_src_hi = ^shsrc_i[DATA_W-1:AMT_W];

   rotr_amount_sel #(.AMT_W(AMT_W)) u_amt (
      .mode   (mode_i),
      .imm    (imm_i),
      .src    (shsrc_i[AMT_W-1:0]),
      .amt    (amt),
      .narrow (narrow),
      .valid  (valid)
   );

   // The low half is doubled so that one wide barrel also serves the narrow modes.
   assign barrel_in = narrow ? {data_i[HALF_W-1:0], data_i[HALF_W-1:0]} : data_i;

   rotr_barrel #(.W(DATA_W)) u_barrel (
      .din  (barrel_in),
      .amt  (amt),
      .dout (barrel_out)
   );

   rotr_extend #(.W(DATA_W), .SIGN_EXT(SIGN_EXT)) u_ext (
      .rot    (barrel_out),
      .narrow (narrow),
      .valid  (valid),
      .dout   (result_o)
   );

   always_comb begin
      if (mode_i > 3'd4)
         a_r8_unused_zero: assert (result_o == '0);
      if (rot_mode_e'(mode_i) == ROT_W64_IMM && imm_i == '0)
         a_r7_zero_pass: assert (result_o == data_i);
      if (rot_mode_e'(mode_i) == ROT_W32_IMM || rot_mode_e'(mode_i) == ROT_W32_REG)
         a_r1_low_ones: assert ($countones(result_o[HALF_W-1:0])
                                == $countones(data_i[HALF_W-1:0]));
      if (rot_mode_e'(mode_i) == ROT_W64_REG || rot_mode_e'(mode_i) == ROT_W64_UP)
         a_r5_wide_ones: assert ($countones(result_o) == $countones(data_i));
   end
endmodule

// File: tb/rotr_unit_bench.sv
module rotr_unit_bench;
   logic        clk = 1'b0;
   logic [2:0]  mode;
   logic [63:0] data;
   logic [63:0] shsrc;
   logic [4:0]  imm;
   logic [63:0] result;
   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   rotr_unit u_rotr_unit (
      .mode_i   (mode),
      .data_i   (data),
      .shsrc_i  (shsrc),
      .imm_i    (imm),
      .result_o (result)
   );

   function automatic logic [63:0] ror_w(input logic [63:0] x, input int n);
      if (n == 0) return x;
      return (x >> n) | (x << (64 - n));
   endfunction

   function automatic logic [63:0] model(input logic [2:0] m, input logic [63:0] d,
                                         input logic [63:0] s, input logic [4:0] i);
      logic [63:0] dbl;
      logic [31:0] lo;
      dbl = {d[31:0], d[31:0]};
      case (m)
         3'd0: begin lo = 32'(ror_w(dbl, int'(i)));        return {{32{lo[31]}}, lo}; end
         3'd1: begin lo = 32'(ror_w(dbl, int'(s[4:0])));   return {{32{lo[31]}}, lo}; end
         3'd2: return ror_w(d, int'(i));
         3'd3: return ror_w(d, int'(i) + 32);
         3'd4: return ror_w(d, int'(s[5:0]));
         default: return 64'd0;
      endcase
   endfunction

   function automatic string req_of(input logic [2:0] m);
      case (m)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd4: return "R5";
         default: return "R8";
      endcase
   endfunction

   task automatic apply(input logic [2:0] m, input logic [63:0] d,
                        input logic [63:0] s, input logic [4:0] i, input string req);
      logic [63:0] exp;
      @(posedge clk);
      mode = m; data = d; shsrc = s; imm = i;
      exp = model(m, d, s, i);
      @(negedge clk);
      checks++;
      if (result !== exp) begin
         errors++;
         $display("FAIL %s mode=%0d act=%h exp=%h", req, m, result, exp);
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      mode = 3'd0; data = '0; shsrc = '0; imm = '0;
      // all-zero inputs
      apply(3'd0, 64'd0, 64'd0, 5'd0, "R7");
      // R7: zero amounts in every mode
      apply(3'd0, 64'h0123_4567_89AB_CDEF, 64'd0, 5'd0, "R7");
      apply(3'd1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFE0, 5'd7, "R7");
      apply(3'd2, 64'h0123_4567_89AB_CDEF, 64'd0, 5'd0, "R7");
      apply(3'd4, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFC0, 5'd3, "R7");
      // R4 bounds: 32 and 63; R3 bound 31; R5 amount 63
      apply(3'd3, 64'h8000_0000_0000_0001, 64'd0, 5'd0, "R4");
      apply(3'd3, 64'h8000_0000_0000_0001, 64'd0, 5'd31, "R4");
      apply(3'd2, 64'h8000_0000_0000_0001, 64'd0, 5'd31, "R3");
      apply(3'd4, 64'h0000_0000_0000_0003, 64'hABCD_0000_0000_007F, 5'd0, "R5");
      // R1: sign bit lands at bit 31 after rotate
      apply(3'd0, 64'h0000_0000_0000_0001, 64'd0, 5'd1, "R1");
      apply(3'd1, 64'h0000_0000_0000_0002, 64'hFFFF_FFFF_FFFF_FFE2, 5'd0, "R2");
      // R6: upper data bits ignored in 32-bit modes
      apply(3'd0, 64'hFFFF_FFFF_1234_5678, 64'd0, 5'd8, "R6");
      apply(3'd0, 64'h0000_0000_1234_5678, 64'd0, 5'd8, "R6");
      apply(3'd1, 64'hA5A5_A5A5_8765_4321, 64'h0000_0001_0000_0024, 5'd0, "R6");
      // R8: unused codes
      apply(3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 5'd5, "R8");
      apply(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 5'd5, "R8");
      apply(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 5'd5, "R8");
      // random patterns across all codes
      for (int n = 0; n < 600; n++) begin
         logic [2:0]  m;
         logic [63:0] d;
         logic [63:0] s;
         m = 3'($urandom_range(0, 7));
         d = {$urandom(), $urandom()};
         s = {$urandom(), $urandom()};
         apply(m, d, s, 5'($urandom()), req_of(m));
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule